// File: doc/BRIEF.md
# Programmable Frame-Sync Pulse Generator

This block produces the periodic frame-synchronization strobe of a serial port. It keeps time in cycles of a generated bit clock. That clock is not a clock net. It arrives as a single-cycle enable, `gclk_en`, in the system clock domain, and the block advances only on system-clock edges where that enable is high.

Two fields shape the strobe. `period_val` (12 bits) sets the frame length and `width_val` (8 bits) sets how long the strobe stays high. Each field feeds its own down-counter. Both counters reload together at every frame boundary. The frame therefore lasts `period_val + 1` enabled cycles, and the strobe is high for `width_val + 1` of them.

The generator runs only while both the run control and the frame-sync mode select are high. Dropping either one parks the block. Raising them again starts a new frame at once, with the strobe high.

Top module: `fsync_gen`

## Requirements
- R1: While `rst_n` is low, and right after its release, `fsync` is 0.
- R2: `fsync` is 0 on the clock after any edge where `run` or `fs_mode` is 0. No pulse appears unless both are 1.
- R3: With both controls high and the width field below the period field, consecutive rising edges of `fsync` are `period_val + 1` enabled cycles apart. With `period_val`=15 and `width_val`=1, a frame is 16 enabled cycles long.
- R4: Each pulse stays high for exactly `width_val + 1` enabled cycles, then falls. With `period_val`=15 and `width_val`=1, it is high for 2.
- R5: On a system-clock edge where `gclk_en` is 0, `fsync` and both counters keep their values.
- R6: Both fields are sampled only at a frame boundary. A change in the middle of a frame first affects the frame that follows.
- R7: If `width_val` >= `period_val`, `fsync` stays 1 continuously. This includes both fields at 0.
- R8: On the first edge where `run` and `fs_mode` are both 1 and `gclk_en` is 1, after an edge where they were not both 1, `fsync` goes to 1 and a fresh frame starts from the current fields.
- R9: The extreme fields work: `period_val`=4095 with `width_val`=255 gives a frame of 4096 enabled cycles with 256 high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gclk_en | input | 1 | One-cycle enable marking each generated bit-clock cycle |
| run | input | 1 | Generator run control |
| fs_mode | input | 1 | Selects the internally generated frame-sync pulse |
| period_val | input | 12 | Frame length minus one, in enabled cycles |
| width_val | input | 8 | Pulse width minus one, in enabled cycles |
| fsync | output | 1 | Frame-synchronization output |

## Verification
A corrupt period count shows up at the ports within one frame as a rising edge of `fsync` in the wrong enabled cycle. A corrupt width count shows up within the same frame as a falling edge in the wrong cycle. A wrong idle or started flag shows up on the first enabled edge after the controls change: the strobe fails to rise, or fails to drop. The bench's reference model predicts `fsync` on every clock, so any of these errors is reported in the cycle it first reaches the output.

// File: rtl/fsync_gen_pkg.sv
`timescale 1ns/1ps
package fsync_gen_pkg;
   localparam int PER_W_DEF = 12;
   localparam int WID_W_DEF = 8;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_HIGH = 2'd1,
      FS_LOW  = 2'd2
   } fs_state_e;
endpackage

// File: rtl/fsync_gen_dcnt.sv
`timescale 1ns/1ps
module fsync_gen_dcnt #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic         dec,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         zero
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (clr)
         q <= '0;
      else if (load)
         q <= load_val;
      else if (dec && (q != '0))
         q <= q - ONE;
   end

   assign cnt  = q;
   assign zero = (q == '0);
endmodule

// File: rtl/fsync_gen_ctrl.sv
`timescale 1ns/1ps
module fsync_gen_ctrl
   import fsync_gen_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      active,
   input  logic      step_en,
   input  logic      per_zero,
   input  logic      wid_zero,
   output logic      clr,
   output logic      load,
   output logic      adv,
   output fs_state_e state,
   output logic      fsync
);
   fs_state_e state_q, state_d;
   logic      step;

   assign step = active & step_en;
   assign clr  = ~active;
   assign load = step & ((state_q == FS_IDLE) | per_zero);
   assign adv  = step & ~load;

   always_comb begin
      state_d = state_q;
      if (!active)
         state_d = FS_IDLE;
      else if (load)
         state_d = FS_HIGH;
      else if (adv && (state_q == FS_HIGH) && wid_zero)
         state_d = FS_LOW;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= FS_IDLE;
      else
         state_q <= state_d;
   end

   assign state = state_q;

   generate
      if (REG_OUT) begin : g_reg_out
         logic fs_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               fs_q <= 1'b0;
            else
               fs_q <= (state_d == FS_HIGH);
         end
         assign fsync = fs_q;
      end else begin : g_dec_out
         assign fsync = (state_q == FS_HIGH);
      end
   endgenerate
endmodule

// File: rtl/fsync_gen.sv
`timescale 1ns/1ps
module fsync_gen
   import fsync_gen_pkg::*;
#(
   parameter int PER_W   = PER_W_DEF,
   parameter int WID_W   = WID_W_DEF,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gclk_en,
   input  logic             run,
   input  logic             fs_mode,
   input  logic [PER_W-1:0] period_val,
   input  logic [WID_W-1:0] width_val,
   output logic             fsync
);
   generate
      if (PER_W < 2 || PER_W > 32) begin : g_bad_per
         $error("fsync_gen: PER_W must lie in 2..32");
      end
      if (WID_W < 1 || WID_W > PER_W) begin : g_bad_wid
         $error("fsync_gen: WID_W must lie in 1..PER_W");
      end
   endgenerate

   logic             active;
   logic             clr, load, adv;
   logic             per_zero, wid_zero;
   logic [PER_W-1:0] per_cnt;
   logic [WID_W-1:0] wid_cnt;
   fs_state_e        state;

   assign active = run & fs_mode;

   fsync_gen_dcnt #(.W(PER_W)) u_per (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .dec(adv),
      .load_val(period_val), .cnt(per_cnt), .zero(per_zero)
   );

   fsync_gen_dcnt #(.W(WID_W)) u_wid (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .dec(adv),
      .load_val(width_val), .cnt(wid_cnt), .zero(wid_zero)
   );

   fsync_gen_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .active(active), .step_en(gclk_en),
      .per_zero(per_zero), .wid_zero(wid_zero), .clr(clr), .load(load),
      .adv(adv), .state(state), .fsync(fsync)
   );
endmodule

// File: rtl/fsync_gen_checker.sv
`timescale 1ns/1ps
module fsync_gen_checker
   import fsync_gen_pkg::*;
#(
   parameter int PER_W = 12,
   parameter int WID_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             gclk_en,
   input logic             run,
   input logic             fs_mode,
   input logic [PER_W-1:0] period_val,
   input logic [WID_W-1:0] width_val,
   input logic             fsync,
   input logic [PER_W-1:0] per_cnt,
   input logic [WID_W-1:0] wid_cnt,
   input fs_state_e        state
);
   logic act, started;
   assign act     = run & fs_mode;
   assign started = (state != FS_IDLE);

   always @(posedge clk) begin
      if (!rst_n)
         assert_reset_low_R1: assert (!fsync);
   end

   assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> !fsync);

   assert_hold_no_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !gclk_en) |=> (fsync == $past(fsync) && per_cnt == $past(per_cnt)
                             && wid_cnt == $past(wid_cnt)));

   assert_fresh_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!act ##1 (act && gclk_en)) |=> fsync);

   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act && gclk_en && started && per_cnt == '0) |=>
      (fsync && per_cnt == $past(period_val) && wid_cnt == $past(width_val)));

   assert_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act && gclk_en && fsync && wid_cnt == '0 && per_cnt != '0) |=> !fsync);

   assert_stay_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act && gclk_en && fsync && wid_cnt != '0) |=> fsync);
endmodule

bind fsync_gen fsync_gen_checker #(.PER_W(PER_W), .WID_W(WID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .gclk_en(gclk_en), .run(run), .fs_mode(fs_mode),
   .period_val(period_val), .width_val(width_val), .fsync(fsync),
   .per_cnt(per_cnt), .wid_cnt(wid_cnt), .state(state)
);

// File: tb/fsync_gen_test.sv
`timescale 1ns/1ps
module fsync_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gclk_en = 1'b0;
   logic        run = 1'b0;
   logic        fs_mode = 1'b0;
   logic [11:0] period_val = 12'd0;
   logic [7:0]  width_val = 8'd0;
   logic        fsync;

   int    errors = 0;
   int    checks = 0;
   string cur_req = "R1";
   int    ce_div = 1;
   int    ce_cnt = 0;
   bit    ce_off = 1'b0;
   bit    cmp_en = 1'b0;

   // reference model state
   bit r_started = 0;
   bit r_fs = 0;
   int r_pos = 0;
   int r_per = 0;
   int r_wid = 0;

   always #2.5 clk = ~clk;

   fsync_gen uut (
      .clk(clk), .rst_n(rst_n), .gclk_en(gclk_en), .run(run), .fs_mode(fs_mode),
      .period_val(period_val), .width_val(width_val), .fsync(fsync)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // enable generator, driven away from the active edge
   always @(negedge clk) begin
      if (ce_off) begin
         gclk_en = 1'b0;
      end else begin
         gclk_en = (ce_cnt == 0);
         ce_cnt = (ce_cnt >= ce_div - 1) ? 0 : ce_cnt + 1;
      end
   end

   // behavioural reference: position inside frame counted upward
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_started = 0; r_fs = 0; r_pos = 0;
      end else if (!(run && fs_mode)) begin
         r_started = 0; r_fs = 0;
      end else if (gclk_en) begin
         if (!r_started || r_pos == r_per) begin
            r_started = 1; r_pos = 0;
            r_per = int'(period_val); r_wid = int'(width_val);
         end else begin
            r_pos++;
         end
         r_fs = (r_pos <= r_wid);
      end
   end

   always @(negedge clk) begin
      if (cmp_en && rst_n)
         check(fsync == r_fs, cur_req, fsync, r_fs);
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic measure(input int exp_hi, input int exp_per, input string req);
      int hi = 0;
      int lo = 0;
      while (fsync !== 1'b0) @(negedge clk);
      while (fsync !== 1'b1) @(negedge clk);
      while (fsync === 1'b1) begin hi++; @(negedge clk); end
      while (fsync === 1'b0) begin lo++; @(negedge clk); end
      check(hi == exp_hi, {req, " width"}, hi, exp_hi);
      check(hi + lo == exp_per, {req, " period"}, hi + lo, exp_per);
   endtask

   task automatic hold_high(input int n, input string req);
      bit ok = 1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (fsync !== 1'b1) ok = 0;
      end
      check(ok, req, fsync, 1);
   endtask

   task automatic restart(input int p, input int w, input int div);
      run = 1'b0;
      @(negedge clk);
      period_val = 12'(p); width_val = 8'(w); ce_div = div; ce_cnt = 0;
      run = 1'b1;
   endtask

   initial begin
      // R1: reset state
      cur_req = "R1";
      run = 1'b1; fs_mode = 1'b1; period_val = 12'd15; width_val = 8'd1;
      cycles(5);
      check(fsync == 1'b0, "R1", fsync, 0);
      run = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(fsync == 1'b0, "R1", fsync, 0);
      cmp_en = 1'b1;

      // R2: either control low keeps output low
      cur_req = "R2";
      run = 1'b1; fs_mode = 1'b0;
      cycles(40);
      check(fsync == 1'b0, "R2", fsync, 0);
      run = 1'b0; fs_mode = 1'b1;
      cycles(40);
      check(fsync == 1'b0, "R2", fsync, 0);

      // R3 R4: nominal 16-cycle frame, 2 high
      cur_req = "R3";
      restart(15, 1, 1);
      measure(2, 16, "R3 R4");
      measure(2, 16, "R3 R4");
      cur_req = "R4";
      restart(9, 4, 2);
      measure(10, 20, "R4");

      // R5: sparse enable and held-off enable
      cur_req = "R5";
      restart(15, 1, 3);
      measure(6, 48, "R5");
      begin
         bit same = 1;
         logic snap;
         cycles(7);
         ce_off = 1'b1;
         @(negedge clk);
         snap = fsync;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (fsync !== snap) same = 0;
         end
         check(same, "R5", fsync, snap);
         ce_off = 1'b0;
      end
      measure(6, 48, "R5");

      // R6: fields change mid-frame
      cur_req = "R6";
      restart(7, 2, 1);
      measure(3, 8, "R6");
      while (fsync !== 1'b1) @(negedge clk);
      @(negedge clk);
      period_val = 12'd11; width_val = 8'd5;
      begin
         int hi_old = 1;
         while (fsync === 1'b1) begin hi_old++; @(negedge clk); end
         check(hi_old == 3, "R6 old width", hi_old, 3);
      end
      measure(6, 12, "R6");

      // R7: width not below period
      cur_req = "R7";
      restart(0, 0, 1);
      cycles(3);
      hold_high(40, "R7 zero fields");
      restart(3, 200, 2);
      cycles(3);
      hold_high(40, "R7 wide");
      restart(5, 5, 1);
      cycles(3);
      hold_high(40, "R7 equal");

      // R8: drop mid-pulse, re-enable starts fresh
      cur_req = "R8";
      restart(11, 5, 1);
      while (fsync !== 1'b1) @(negedge clk);
      cycles(2);
      fs_mode = 1'b0;
      @(negedge clk);
      check(fsync == 1'b0, "R8 drop", fsync, 0);
      cycles(3);
      fs_mode = 1'b1;
      @(negedge clk);
      check(fsync == 1'b1, "R8 restart", fsync, 1);
      begin
         int hi = 1;
         @(negedge clk);
         while (fsync === 1'b1) begin hi++; @(negedge clk); end
         check(hi == 6, "R8 fresh width", hi, 6);
      end

      // R9: extreme fields
      cur_req = "R9";
      restart(4095, 255, 1);
      measure(256, 4096, "R9");

      cmp_en = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(190000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done at %0t", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule